// File: doc/BRIEF.md
# Reference-Locked Oscillator Trim Controller

This block calibrates a digitally tuned oscillator against a slow, accurate reference clock. The controller runs on the oscillator's own clock. A free-running counter advances on every fast-clock cycle. The reference input is synchronised into that domain, and every fourth rising reference edge ends a measurement window. At the end of each window the counter is captured. The number of fast cycles in the window is the modulo difference between this capture and the one before it.

That count is compared with a target. With a 32768 Hz reference and a 2.048 MHz goal, the target is 250 cycles per four reference periods. The 8-bit trim code is nudged one step toward the target after every window. When a window holds exactly the target count, the controller freezes the code, stops its counter and raises `locked`. A later `start` strobe recalibrates from the code already held, which makes periodic re-trimming cheap.

Top module: `osc_trim_ctrl`

## Requirements
- R1: A synchronous reset sets `trim_code` to 0x80 and `locked` to 0. The controller then stays idle and leaves the code alone until `start` is seen.
- R2: `ref_in` passes through a two-flop synchroniser. Every fourth rising edge of the synchronised signal, counted from reset, ends a window. If `ref_in` is first sampled high at fast-clock edge k, the window it closes is acted on at edge k+2.
- R3: After `start`, the first window boundary only records the counter value. It never changes `trim_code` or `locked`.
- R4: The measured count is the 16-bit modulo difference between successive counter captures. The counter is never cleared between windows, and a wrap inside a window still gives the true cycle count.
- R5: If a window's count is below the target (250), `trim_code` rises by one at the edge that ends the window.
- R6: If a window's count is above the target, `trim_code` falls by one at that edge.
- R7: If a window's count equals the target, `locked` goes to 1 at that edge and `trim_code` keeps its value. After that, windows are ignored and the counter halts until the next accepted `start`.
- R8: `trim_code` saturates. At 0x00 a further decrement leaves it at 0x00, and at 0xFF a further increment leaves it at 0xFF.
- R9: `start` is accepted only when the controller is idle or locked. Acceptance clears `locked` at the next edge and keeps the current `trim_code`. A `start` while a calibration is running has no effect.
- R10: If `start` arrives in the same cycle as a window boundary while locked, the restart wins. That boundary is not measured, and the next boundary only records the counter (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from the tuned oscillator |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous slow reference clock |
| start | input | 1 | Single-cycle request to begin calibration |
| trim_code | output | 8 | Registered oscillator trim value |
| locked | output | 1 | Registered flag: last window matched the target |

## Verification
Two events can land in the same fast-clock cycle. One is a restart strobe. The other is the window-end pulse that would otherwise be judged against the target. The bench tracks the synchroniser and divider phase in its model, and it raises `start` in exactly the cycle where the model predicts a window end while locked. Its per-cycle comparison then requires `locked` to drop, the code to stay still on that boundary and the following one, and stepping to resume only one window later. A second overlap, a counter wrap inside a window, comes from running unlocked for more than 65536 cycles. Stepping stays correct through that wrap because the model counts elapsed cycles instead of subtracting captured values.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARM    = 2'd1,
    ST_TRACK  = 2'd2,
    ST_LOCKED = 2'd3
  } trim_state_t;
endpackage

// File: rtl/ref_window_gen.sv
// Synchronises the reference and emits one pulse per REF_DIV reference rises.
module ref_window_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int REF_DIV     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic win_pulse
);
  localparam int DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [DIV_W-1:0]       div_q;
  logic                   rise;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= ref_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b0;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rise      = sync_q[SYNC_STAGES-1] & ~last_q;
  assign win_pulse = rise && (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      div_q  <= '0;
    end else begin
      last_q <= sync_q[SYNC_STAGES-1];
      if (rise) div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  // R2: a window boundary is a single-cycle event
  p_pulse_gap_r2: assert property (@(posedge clk) disable iff (rst)
    win_pulse |=> !win_pulse);
endmodule

// File: rtl/free_counter.sv
// Free-running cycle counter, never cleared except by reset.
module free_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  // R7: counter is frozen while calibration is not running
  p_hold_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
endmodule

// File: rtl/trim_stepper.sv
// Window evaluation and saturating one-step trim adjustment.
module trim_stepper import osc_trim_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int TRIM_W    = 8,
  parameter int TARGET    = 250,
  parameter int TRIM_INIT = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              win_pulse,
  input  logic [CNT_W-1:0]  cnt,
  output logic [TRIM_W-1:0] trim_code,
  output logic              locked,
  output logic              count_en
);
  localparam logic [CNT_W-1:0]  TARGET_C = CNT_W'(TARGET);
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
  localparam logic [TRIM_W-1:0] TRIM_MIN = '0;
  localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(TRIM_INIT);

  trim_state_t      state_q;
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] span;

  assign span     = cnt - prev_q;
  assign count_en = (state_q == ST_ARM) || (state_q == ST_TRACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      prev_q    <= '0;
      trim_code <= TRIM_RST;
      locked    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) state_q <= ST_ARM;
        end
        ST_LOCKED: begin
          if (start) begin
            state_q <= ST_ARM;
            locked  <= 1'b0;
          end
        end
        ST_ARM: begin
          if (win_pulse) begin
            prev_q  <= cnt;
            state_q <= ST_TRACK;
          end
        end
        ST_TRACK: begin
          if (win_pulse) begin
            prev_q <= cnt;
            if (span < TARGET_C) begin
              if (trim_code != TRIM_MAX) trim_code <= trim_code + 1'b1;
            end else if (span > TARGET_C) begin
              if (trim_code != TRIM_MIN) trim_code <= trim_code - 1'b1;
            end else begin
              locked  <= 1'b1;
              state_q <= ST_LOCKED;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5/R6: the code moves only on a window boundary
  p_step_on_window_r5: assert property (@(posedge clk) disable iff (rst)
    !win_pulse |=> $stable(trim_code));
  // R3: the arming boundary never moves the code
  p_first_no_step_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARM) |=> $stable(trim_code));
  // R7: lock holds code and flag until a restart
  p_locked_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && !start) |=> (locked && $stable(trim_code)));
  // R7: lock rises only on a window boundary
  p_lock_on_window_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(win_pulse));
  // R8: no wrap at either end
  p_no_wrap_top_r8: assert property (@(posedge clk) disable iff (rst)
    (trim_code == TRIM_MAX) |=> (trim_code != TRIM_MIN));
  p_no_wrap_bottom_r8: assert property (@(posedge clk) disable iff (rst)
    (trim_code == TRIM_MIN) |=> (trim_code != TRIM_MAX));
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter int CNT_W       = 16,
  parameter int TRIM_W      = 8,
  parameter int TARGET      = 250,
  parameter int TRIM_INIT   = 128,
  parameter int REF_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              start,
  output logic [TRIM_W-1:0] trim_code,
  output logic              locked
);
  logic             win_pulse;
  logic             count_en;
  logic [CNT_W-1:0] cnt;

  ref_window_gen #(.SYNC_STAGES(SYNC_STAGES), .REF_DIV(REF_DIV)) u_window (
    .clk(clk), .rst(rst), .ref_in(ref_in), .win_pulse(win_pulse)
  );

  free_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .en(count_en), .cnt(cnt)
  );

  trim_stepper #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .TARGET(TARGET),
                 .TRIM_INIT(TRIM_INIT)) u_stepper (
    .clk(clk), .rst(rst), .start(start), .win_pulse(win_pulse), .cnt(cnt),
    .trim_code(trim_code), .locked(locked), .count_en(count_en)
  );
endmodule

// File: tb/test_osc_trim_ctrl.sv
module test_osc_trim_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TARGET     = 250;
  localparam int BASE_P     = 62;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic       start = 1'b0;
  logic [7:0] trim_code;
  logic       locked;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  osc_trim_ctrl i_osc_trim_ctrl (
    .clk(clk), .rst(rst), .ref_in(ref_in), .start(start),
    .trim_code(trim_code), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int    m_hist[$];         // ref_in samples, newest at back
  int    m_rises;           // synchronised rises seen
  int    m_state;           // 0 idle, 1 arm, 2 track, 3 locked
  int    m_trim;
  bit    m_locked;
  int    m_elapsed;         // cycles counted since last capture
  longint m_total;          // all counted cycles
  string m_tag = "R1";

  // is a window boundary visible to the design in the coming edge?
  function automatic bit boundary_due();
    if (m_hist.size() < 3) return 0;
    return (m_hist[m_hist.size()-2] == 1) && (m_hist[m_hist.size()-3] == 0)
           && (m_rises % 4 == 3);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_hist.delete();
      m_rises = 0; m_state = 0; m_trim = 128; m_locked = 0;
      m_elapsed = 0; m_tag = "R1";
    end else begin
      bit rise_seen, win, running;
      rise_seen = (m_hist.size() >= 3) && (m_hist[m_hist.size()-2] == 1)
                  && (m_hist[m_hist.size()-3] == 0);
      win = boundary_due();
      running = (m_state == 1) || (m_state == 2);
      if (rise_seen) m_rises++;
      case (m_state)
        0: if (start) begin m_state = 1; m_tag = "R9"; end
        3: if (start) begin
             m_state = 1; m_locked = 0;
             m_tag = win ? "R10" : "R9";
           end
        1: if (win) begin m_state = 2; m_elapsed = 0; m_tag = "R3"; end
        2: if (win) begin
             if (m_elapsed < TARGET) begin
               m_tag = (m_trim == 255) ? "R8" : "R5";
               if (m_trim < 255) m_trim++;
             end else if (m_elapsed > TARGET) begin
               m_tag = (m_trim == 0) ? "R8" : "R6";
               if (m_trim > 0) m_trim--;
             end else begin
               m_locked = 1; m_state = 3; m_tag = "R7";
             end
             m_elapsed = 0;
           end
        default: ;
      endcase
      if (running) begin m_elapsed++; m_total++; end
    end
    m_hist.push_back(rst ? 0 : int'(ref_in));
    if (m_hist.size() > 4) void'(m_hist.pop_front());
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (trim_code != m_trim[7:0] || locked != m_locked) begin
        errors++;
        $display("FAIL %s cycle check: trim=%0h locked=%0b expected trim=%0h locked=%0b",
                 m_tag, trim_code, locked, m_trim, m_locked);
      end
    end
  end

  // ---------------- oscillator / reference stimulus ----------------
  int lock_trim = 96;
  bit gen_on = 0;
  int g_rise = 0, g_t = 0, g_p = BASE_P, g_p2 = BASE_P, g_p3 = BASE_P;

  // fast cycles per window as a function of the code
  function automatic int window_len(int code);
    int w;
    w = TARGET + code - lock_trim;
    if (w < 130) w = 130;
    if (w > 420) w = 420;
    return w;
  endfunction

  always @(negedge clk) begin
    if (!gen_on) begin
      ref_in <= 1'b0; g_rise = 0; g_t = 0;
    end else begin
      if (g_t == 0) begin
        int rest, q;
        g_rise++;
        case (g_rise % 4)
          0: g_p = BASE_P;
          1: begin
               rest = window_len(m_trim) - BASE_P;
               q = rest / 3;
               g_p = q; g_p2 = q; g_p3 = rest - 2 * q;
             end
          2: g_p = g_p2;
          default: g_p = g_p3;
        endcase
      end
      ref_in <= (g_t < g_p / 2);
      g_t = (g_t + 1 == g_p) ? 0 : g_t + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    gen_on = 0; rst = 1;
    repeat (5) @(negedge clk);
    rst = 0; gen_on = 1;
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_until_locked(input int limit);
    for (int i = 0; i < limit && !m_locked; i++) @(negedge clk);
  endtask

  task automatic wait_trim(input int code, input int limit);
    for (int i = 0; i < limit && m_trim != code; i++) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int err_mark, stuck;
    longint tot_mark;
    do_reset();
    // R1: reset values, then idle with the reference running
    check("R1", trim_code, 8'h80);
    check("R1", locked, 0);
    repeat (700) @(negedge clk);
    check("R1", trim_code, 8'h80);

    // R6/R7: oscillator too fast, code steps down to the lock point
    lock_trim = 8'h60;
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();                       // R9: ignored while tracking
    wait_until_locked(20000);
    check("R6", trim_code, 8'h60);
    check("R7", locked, 1);
    repeat (1500) @(negedge clk);
    check("R7", trim_code, 8'h60);

    // R10: restart in the exact cycle of a window boundary
    lock_trim = 8'h64;
    stuck = 0;
    while (!boundary_due() && stuck < 2000) begin @(negedge clk); stuck++; end
    pulse_start();
    check("R10", locked, 0);
    check("R9", trim_code, 8'h60);       // code retained across restart
    wait_until_locked(20000);
    check("R5", trim_code, 8'h64);
    check("R9", locked, 1);

    // R8 and R4: long unlocked runs through both saturation limits
    do_reset();
    lock_trim = -10;
    err_mark = errors;
    tot_mark = m_total;
    pulse_start();
    wait_trim(0, 60000);
    repeat (6000) @(negedge clk);
    check("R8", trim_code, 8'h00);
    lock_trim = 300;
    wait_trim(255, 70000);
    repeat (6000) @(negedge clk);
    check("R8", trim_code, 8'hFF);
    check("R8", locked, 0);
    // R4: more than 65536 counted cycles passed with no mismatch
    check("R4", (m_total - tot_mark > 65536) ? errors - err_mark : -1, 0);
    report();
  end
endmodule